// File: doc/BRIEF.md
# Interrupt redirection table controller

This block routes a set of interrupt input lines to a single request channel. Every line owns a 64-bit redirection entry. The entry names the vector that the request carries, a 3-bit delivery mode, a logical/physical destination-mode bit and an 8-bit destination. It also chooses between edge and level sensing, sets the active polarity and holds a mask. The request goes out with the vector already attached, so the receiver never has to run an acknowledge cycle to fetch it.

Software reaches every register through two byte addresses. Byte address 0x00 is an index register that holds an 8-bit register number. Byte address 0x10 is a data window onto the 32-bit register that the index selects. Register 0x01 identifies the block. The table starts at register 0x10.

When more than one line is ready, the lowest-numbered line is sent first. The request channel is a valid/ready pair. After a level-sensitive line is delivered, it stays blocked until an end-of-interrupt message names its vector.

Top module: `irt_router`

## Requirements
- R1: A bus write to byte address 0x00 loads the index register from bits 7:0 of the write data. A read of byte address 0x00 returns the index in bits 7:0, with zeros above. Reads and writes of byte address 0x10 reach the register the index selects. Registers that do not exist read as zero.
- R2: Register 0x01 reads 0x0000_0020 with (number of lines − 1) placed in bits 23:16. For 24 lines this is 0x0017_0020.
- R3: Line n keeps its low word at register 0x10+2n and its high word at 0x10+2n+1. The low-word fields are: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12 (read-only), polarity 13 (1 = active low), remote-pending 14 (read-only), trigger 15 (1 = level) and mask 16. All other bits read zero. In the high word only bits 31:24 (the destination) are stored; the rest read zero.
- R4: After reset every low word reads 0x0001_0000, every high word reads 0, and no request is valid.
- R5: A line whose mask bit is 1 raises no request. An edge that arrives while the line is masked is dropped.
- R6: In edge mode, an inactive-to-active transition of the input latches exactly one request. Holding the input active afterwards adds no further request. With polarity 1 the active transition is a falling edge.
- R7: In level mode, an active and unblocked line requests. Acceptance of that request sets remote-pending (bit 14), and the line does not request again until an end-of-interrupt carries a vector equal to the line's vector. An end-of-interrupt with any other vector has no effect.
- R8: The request carries the line's vector, delivery mode, destination mode and destination as they stood when the line was granted. These outputs hold steady while the request is valid and not yet accepted, even if software rewrites the entry.
- R9: When several lines are ready at once, they are sent in ascending line order.
- R10: Delivery status (bit 12) reads 1 while a line is unmasked and ready but not yet accepted, and reads 0 once it is blocked by remote-pending.
- R11: If a level line's request is accepted in the same cycle as an end-of-interrupt with that line's vector, remote-pending ends up set and the line stays blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address: 0x00 index, 0x10 data window |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Bus read data for busAddr (combinational) |
| irqIn | input | NUM_LINES | Interrupt input lines, synchronous to clk |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector named by the end-of-interrupt |
| reqValid | output | 1 | Request valid |
| reqReady | input | 1 | Receiver accepts the request |
| reqVector | output | 8 | Vector of the request |
| reqDelMode | output | 3 | Delivery mode of the request |
| reqDestMode | output | 1 | Destination mode (1 = logical) |
| reqDest | output | 8 | Destination of the request |

## Verification
Two events can land on the same edge: a level line's request is accepted, which sets remote-pending, and an end-of-interrupt arrives that would clear it. The bench raises reqReady and an end-of-interrupt with the granted line's vector on the same cycle. It then expects bit 14 to read 1 and no new request to appear while the input stays active. A later end-of-interrupt sent on its own must bring the request back. The second overlap is a table write during a pending request: the bench rewrites the vector and expects the request outputs to stay unchanged.

// File: rtl/irt_pkg.sv
`timescale 1ns/1ps
package irt_pkg;
  localparam logic [7:0] IDX_ADDR = 8'h00;
  localparam logic [7:0] DATA_ADDR = 8'h10;
  localparam logic [7:0] ID_REG = 8'h01;
  localparam logic [7:0] TBL_BASE = 8'h10;
  localparam logic [7:0] ID_VALUE = 8'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic        loWr;
    logic        hiWr;
    logic [7:0]  wrLine;
    logic [31:0] wrData;
    logic        accept;
    logic [7:0]  acceptLine;
  } irt_strobe_t;
endpackage

// File: rtl/irt_dpath.sv
`timescale 1ns/1ps
module irt_dpath
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irt_strobe_t          stb,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 eoiValid,
  input  logic [7:0]           eoiVector,
  input  logic [LW-1:0]        rdLine,
  output logic [31:0]          rdLo,
  output logic [31:0]          rdHi,
  input  logic [LW-1:0]        winLine,
  output logic [7:0]           winVector,
  output logic [2:0]           winDelMode,
  output logic                 winDestMode,
  output logic [7:0]           winDest,
  output logic [NUM_LINES-1:0] eligible
);
  logic [7:0] vecQ  [NUM_LINES];
  logic [2:0] dmQ   [NUM_LINES];
  logic [7:0] destQ [NUM_LINES];
  logic [NUM_LINES-1:0] dstModeQ, polQ, trigQ, maskQ, rirrQ, pendQ, prevQ;
  logic [NUM_LINES-1:0] active;

  assign active = irqIn ^ polQ;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      eligible[i] = !maskQ[i] && (trigQ[i] ? (active[i] && !rirrQ[i]) : pendQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        vecQ[i]  <= '0;
        dmQ[i]   <= '0;
        destQ[i] <= '0;
      end
      dstModeQ <= '0; polQ <= '0; trigQ <= '0; maskQ <= '1;
      rirrQ <= '0; pendQ <= '0; prevQ <= '0;
    end else begin
      prevQ <= active;
      for (int i = 0; i < NUM_LINES; i++) begin
        logic acc, eoiHit;
        acc    = stb.accept && (stb.acceptLine[LW-1:0] == LW'(i));
        eoiHit = eoiValid && (eoiVector == vecQ[i]);
        // edge capture
        if (trigQ[i] || (acc && !trigQ[i]))
          pendQ[i] <= 1'b0;
        else if (!maskQ[i] && active[i] && !prevQ[i])
          pendQ[i] <= 1'b1;
        // remote-pending: acceptance wins over a same-cycle EOI
        if (!trigQ[i])
          rirrQ[i] <= 1'b0;
        else if (acc)
          rirrQ[i] <= 1'b1;
        else if (eoiHit)
          rirrQ[i] <= 1'b0;
        // software writes
        if (stb.loWr && stb.wrLine[LW-1:0] == LW'(i)) begin
          vecQ[i]     <= stb.wrData[7:0];
          dmQ[i]      <= stb.wrData[10:8];
          dstModeQ[i] <= stb.wrData[11];
          polQ[i]     <= stb.wrData[13];
          trigQ[i]    <= stb.wrData[15];
          maskQ[i]    <= stb.wrData[16];
        end
        if (stb.hiWr && stb.wrLine[LW-1:0] == LW'(i))
          destQ[i] <= stb.wrData[31:24];
      end
    end
  end

  assign rdLo = {15'b0, maskQ[rdLine], trigQ[rdLine], rirrQ[rdLine], polQ[rdLine],
                 eligible[rdLine], dstModeQ[rdLine], dmQ[rdLine], vecQ[rdLine]};
  assign rdHi = {destQ[rdLine], 24'b0};

  assign winVector   = vecQ[winLine];
  assign winDelMode  = dmQ[winLine];
  assign winDestMode = dstModeQ[winLine];
  assign winDest     = destQ[winLine];

  for (genvar g = 0; g < NUM_LINES; g++) begin : gChk
    assert_rirr_set_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rirrQ[g]) |-> $past(stb.accept && stb.acceptLine[LW-1:0] == LW'(g)));
    assert_rirr_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rirrQ[g]) |-> $past((eoiValid && eoiVector == vecQ[g]) || !trigQ[g]));
  end
endmodule

// File: rtl/irt_ctrl.sv
`timescale 1ns/1ps
module irt_ctrl
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output irt_strobe_t          stb,
  output logic [LW-1:0]        rdLine,
  input  logic [31:0]          rdLo,
  input  logic [31:0]          rdHi,
  output logic [LW-1:0]        winLine,
  input  logic [7:0]           winVector,
  input  logic [2:0]           winDelMode,
  input  logic                 winDestMode,
  input  logic [7:0]           winDest,
  input  logic [NUM_LINES-1:0] eligible,
  output logic                 reqValid,
  input  logic                 reqReady,
  output logic [7:0]           reqVector,
  output logic [2:0]           reqDelMode,
  output logic                 reqDestMode,
  output logic [7:0]           reqDest
);
  localparam logic [8:0] TBL_END = 9'(int'(TBL_BASE) + 2 * NUM_LINES);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t stateQ;
  logic [7:0] idxQ, tblOff;
  logic [LW-1:0] curLineQ;
  logic inTable, anyElig;

  assign tblOff  = idxQ - TBL_BASE;
  assign inTable = (idxQ >= TBL_BASE) && ({1'b0, idxQ} < TBL_END);
  assign rdLine  = tblOff[LW:1];

  always_comb begin
    busRdData = '0;
    if (busAddr == IDX_ADDR)
      busRdData = {24'b0, idxQ};
    else if (busAddr == DATA_ADDR) begin
      if (idxQ == ID_REG)
        busRdData = {8'b0, 8'(NUM_LINES - 1), 8'b0, ID_VALUE};
      else if (inTable)
        busRdData = tblOff[0] ? rdHi : rdLo;
    end
  end

  always_comb begin
    winLine = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (eligible[i]) winLine = LW'(i);
  end
  assign anyElig = |eligible;

  always_comb begin
    stb            = '0;
    stb.wrData     = busWrData;
    stb.wrLine     = 8'(rdLine);
    stb.loWr       = busWrEn && busAddr == DATA_ADDR && inTable && !tblOff[0];
    stb.hiWr       = busWrEn && busAddr == DATA_ADDR && inTable && tblOff[0];
    stb.accept     = (stateQ == ST_SEND) && reqReady;
    stb.acceptLine = 8'(curLineQ);
  end

  assign reqValid = (stateQ == ST_SEND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      stateQ <= ST_IDLE;
      curLineQ <= '0;
      reqVector <= '0; reqDelMode <= '0; reqDestMode <= 1'b0; reqDest <= '0;
    end else begin
      if (busWrEn && busAddr == IDX_ADDR) idxQ <= busWrData[7:0];
      case (stateQ)
        ST_IDLE: if (anyElig) begin
          stateQ      <= ST_SEND;
          curLineQ    <= winLine;
          reqVector   <= winVector;
          reqDelMode  <= winDelMode;
          reqDestMode <= winDestMode;
          reqDest     <= winDest;
        end
        default: if (reqReady) stateQ <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable({reqVector, reqDelMode, reqDestMode, reqDest}));
  assert_one_per_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid);
endmodule

// File: rtl/irt_router.sv
`timescale 1ns/1ps
module irt_router
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 eoiValid,
  input  logic [7:0]           eoiVector,
  output logic                 reqValid,
  input  logic                 reqReady,
  output logic [7:0]           reqVector,
  output logic [2:0]           reqDelMode,
  output logic                 reqDestMode,
  output logic [7:0]           reqDest
);
  localparam int LW = $clog2(NUM_LINES);

  irt_strobe_t stb;
  logic [LW-1:0] rdLine, winLine;
  logic [31:0] rdLo, rdHi;
  logic [7:0] winVector, winDest;
  logic [2:0] winDelMode;
  logic winDestMode;
  logic [NUM_LINES-1:0] eligible;

  irt_ctrl #(.NUM_LINES(NUM_LINES), .LW(LW)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .stb(stb), .rdLine(rdLine),
    .rdLo(rdLo), .rdHi(rdHi), .winLine(winLine), .winVector(winVector),
    .winDelMode(winDelMode), .winDestMode(winDestMode), .winDest(winDest),
    .eligible(eligible), .reqValid(reqValid), .reqReady(reqReady),
    .reqVector(reqVector), .reqDelMode(reqDelMode), .reqDestMode(reqDestMode),
    .reqDest(reqDest));

  irt_dpath #(.NUM_LINES(NUM_LINES), .LW(LW)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .irqIn(irqIn), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .rdLine(rdLine), .rdLo(rdLo), .rdHi(rdHi),
    .winLine(winLine), .winVector(winVector), .winDelMode(winDelMode),
    .winDestMode(winDestMode), .winDest(winDest), .eligible(eligible));
endmodule

// File: tb/irt_router_tb.sv
`timescale 1ns/1ps
module irt_router_tb_top;
  localparam int N = 24;
  logic clk = 0, rstN = 0;
  logic [7:0] busAddr = 0;
  logic busWrEn = 0;
  logic [31:0] busWrData = 0, busRdData;
  logic [N-1:0] irqIn = 0;
  logic eoiValid = 0;
  logic [7:0] eoiVector = 0;
  logic reqValid, reqReady = 0, reqDestMode;
  logic [7:0] reqVector, reqDest;
  logic [2:0] reqDelMode;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irt_router #(.NUM_LINES(N)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busWrEn = 0; #1 d = busRdData;
  endtask
  task automatic regW(input logic [7:0] r, input logic [31:0] d);
    wr(8'h00, {24'b0, r}); wr(8'h10, d);
  endtask
  task automatic regR(input logic [7:0] r, output logic [31:0] d);
    wr(8'h00, {24'b0, r}); rd(8'h10, d);
  endtask
  function automatic logic [31:0] lo(input logic [7:0] v, input int dm, input bit dst,
                                     input bit pol, input bit lvl, input bit msk);
    return {15'b0, msk, lvl, 1'b0, pol, 1'b0, dst, 3'(dm), v};
  endfunction
  task automatic waitReq(output bit got);
    got = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (reqValid) begin got = 1; break; end
    end
  endtask
  task automatic quiet(output bit seen);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (reqValid) seen = 1;
    end
  endtask
  task automatic acceptReq();
    @(negedge clk); reqReady = 1;
    @(negedge clk); reqReady = 0;
  endtask
  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoiValid = 1; eoiVector = v;
    @(negedge clk); eoiValid = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit got, seen;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R4: reset state of all entries
    chk("R4 no request after reset", {31'b0, reqValid}, 0);
    for (int n = 0; n < N; n++) begin
      regR(8'(8'h10 + 2 * n), d); chk("R4 low word reset", d, 32'h0001_0000);
      regR(8'(8'h11 + 2 * n), d); chk("R4 high word reset", d, 0);
    end
    // R1 index readback, unused register
    wr(8'h00, 32'hFFFF_FF35); rd(8'h00, d); chk("R1 index readback", d, 32'h35);
    regR(8'h05, d); chk("R1 unused register reads zero", d, 0);
    // R2 identification register
    regR(8'h01, d); chk("R2 id register", d, {8'h0, 8'(N - 1), 8'h0, 8'h20});
    // R3 read-only and unused bits
    regW(8'h10, 32'hFFFF_FFFF); regR(8'h10, d); chk("R3 low word mask of bits", d, 32'h0001_AFFF);
    regW(8'h11, 32'hFFFF_FFFF); regR(8'h11, d); chk("R3 high word dest only", d, 32'hFF00_0000);
    regW(8'h10, 32'h0001_0000); regW(8'h11, 0);

    // R6/R8 edge sweep over every line
    for (int n = 0; n < N; n++) begin
      regW(8'(8'h10 + 2 * n), lo(8'(8'h40 + n), n % 8, n[0], 0, 0, 0));
      regW(8'(8'h11 + 2 * n), {8'hA0 ^ 8'(n), 24'b0});
      @(negedge clk); irqIn[n] = 1;
      waitReq(got);
      chk("R8 edge request fields", {7'b0, got, reqVector, 5'b0, reqDelMode, 7'b0, reqDestMode},
          {7'b0, 1'b1, 8'(8'h40 + n), 5'b0, 3'(n % 8), 7'b0, n[0]});
      chk("R8 edge request dest", {24'b0, reqDest}, {24'b0, 8'hA0 ^ 8'(n)});
      acceptReq();
      quiet(seen); chk("R6 single request per edge", {31'b0, seen}, 0);
      irqIn[n] = 0;
      regW(8'(8'h10 + 2 * n), lo(8'(8'h40 + n), n % 8, n[0], 0, 0, 1));
    end

    // R6 active-low edge on line 3
    @(negedge clk); irqIn[3] = 1;
    regW(8'h16, lo(8'h33, 1, 0, 1, 0, 0));
    quiet(seen); chk("R6 rising edge ignored when active low", {31'b0, seen}, 0);
    @(negedge clk); irqIn[3] = 0;
    waitReq(got); chk("R6 falling edge requests", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h33});
    acceptReq();
    regW(8'h16, lo(8'h33, 1, 0, 0, 0, 1));

    // R5 masked edge dropped, masked level gated
    @(negedge clk); irqIn[5] = 1; @(negedge clk); irqIn[5] = 0;
    regW(8'h1A, lo(8'h55, 0, 0, 0, 0, 0));
    quiet(seen); chk("R5 edge while masked dropped", {31'b0, seen}, 0);
    regW(8'h1A, lo(8'h55, 0, 0, 0, 1, 1));
    @(negedge clk); irqIn[5] = 1;
    quiet(seen); chk("R5 masked level no request", {31'b0, seen}, 0);
    regW(8'h1A, lo(8'h55, 0, 0, 0, 1, 0));
    waitReq(got); chk("R5 unmask releases level", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h55});
    acceptReq();
    regW(8'h1A, lo(8'h55, 0, 0, 0, 1, 1));
    @(negedge clk); irqIn[5] = 0;
    eoi(8'h55);

    // R9 ascending order
    regW(8'h18, lo(8'h84, 0, 0, 0, 0, 0));
    regW(8'h26, lo(8'h8B, 0, 0, 0, 0, 0));
    regW(8'h38, lo(8'h94, 0, 0, 0, 0, 0));
    @(negedge clk); irqIn[4] = 1; irqIn[11] = 1; irqIn[20] = 1;
    waitReq(got); chk("R9 first lowest line", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h84}); acceptReq();
    waitReq(got); chk("R9 second line", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h8B}); acceptReq();
    waitReq(got); chk("R9 third line", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h94}); acceptReq();
    irqIn[4] = 0; irqIn[11] = 0; irqIn[20] = 0;
    regW(8'h18, 32'h0001_0000); regW(8'h26, 32'h0001_0000); regW(8'h38, 32'h0001_0000);

    // R7 level with EOI
    regW(8'h1E, lo(8'h77, 2, 1, 0, 1, 0));
    @(negedge clk); irqIn[7] = 1;
    waitReq(got); chk("R7 level requests", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h77});
    acceptReq();
    regR(8'h1E, d); chk("R7 remote pending set", d, 32'h0000_CA77);
    quiet(seen); chk("R7 blocked until EOI", {31'b0, seen}, 0);
    eoi(8'h56);
    quiet(seen); chk("R7 foreign EOI no effect", {31'b0, seen}, 0);
    regR(8'h1E, d); chk("R7 remote pending kept", d[14], 1);
    eoi(8'h77);
    waitReq(got); chk("R7 matching EOI rearms", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h77});
    acceptReq();
    @(negedge clk); irqIn[7] = 0;
    eoi(8'h77);
    quiet(seen); chk("R7 inactive level silent", {31'b0, seen}, 0);
    regW(8'h1E, 32'h0001_0000);

    // R10 delivery status and R8 hold under rewrite
    regW(8'h14, lo(8'h52, 0, 0, 0, 1, 0));
    regW(8'h22, lo(8'h59, 0, 0, 0, 1, 0));
    @(negedge clk); irqIn[2] = 1; irqIn[9] = 1;
    waitReq(got); chk("R9 line 2 before 9", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h52});
    regR(8'h22, d); chk("R10 waiting line status", {30'b0, d[14], d[12]}, 32'b01);
    regW(8'h14, lo(8'h62, 0, 0, 0, 1, 0));
    chk("R8 request held under rewrite", {23'b0, reqValid, reqVector}, {23'b0, 1'b1, 8'h52});
    acceptReq();
    waitReq(got); chk("R10 next line sent", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h59});
    acceptReq();
    regR(8'h22, d); chk("R10 blocked line status", {30'b0, d[14], d[12]}, 32'b10);
    irqIn[2] = 0; irqIn[9] = 0;
    eoi(8'h62); eoi(8'h59);
    regW(8'h14, 32'h0001_0000); regW(8'h22, 32'h0001_0000);

    // R11 accept and EOI in the same cycle
    regW(8'h1C, lo(8'h66, 0, 0, 0, 1, 0));
    @(negedge clk); irqIn[6] = 1;
    waitReq(got); chk("R11 level request", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h66});
    @(negedge clk); reqReady = 1; eoiValid = 1; eoiVector = 8'h66;
    @(negedge clk); reqReady = 0; eoiValid = 0;
    quiet(seen); chk("R11 set wins over EOI", {31'b0, seen}, 0);
    regR(8'h1C, d); chk("R11 remote pending set", d[14], 1);
    eoi(8'h66);
    waitReq(got); chk("R11 later EOI rearms", {23'b0, got, reqVector}, {23'b0, 1'b1, 8'h66});
    acceptReq();
    irqIn[6] = 0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule